// File: doc/BRIEF.md
# Character-Fetch Text Video Controller

This block produces text video by borrowing the CPU's own instruction fetches. While the CPU "executes" the display file, the block watches each opcode fetch that has been flagged as a display fetch. It captures the byte read from display memory and then drives zero onto the data bus the CPU sees, so the CPU decodes a NOP and moves on to the next byte. The captured byte gives a six-bit character code and an invert flag.

The CPU follows each fetch with a refresh cycle. During that cycle the block supplies a character-pattern ROM address. The upper bits come from the CPU's I register, the middle bits from the character code, and the low three bits from a scan-line counter. On the falling CPU clock edge of T4 the returned pattern byte is loaded into a shift register. The byte is then sent out as eight pixels at twice the CPU clock rate. The CPU clock itself is derived from the master clock: four master cycles per T-state, and two master cycles per pixel.

The master clock runs at twice the pixel rate. Capture is taken by default on the falling CPU edge inside T2, which leaves slow display memory half a T-state more to settle. A parameter moves capture to the rising edge of T2.

Top module: `charfetch_video`

## Requirements
- R1: On capture, data bits 5..0 become the character code and bit 7 becomes the invert flag; bit 6 has no effect on the address or the pixels.
- R2: After a display-fetch capture in T2, `bus_zero_o` is 1 and `bus_q_o` reads 8'h00 for the rest of T2 and all of T3; both are released one master cycle into T4.
- R3: When `disp_en_i` or `m1_i` is low, no capture takes place and `bus_q_o` equals `data_i` throughout the fetch.
- R4: `rom_addr_o` = {`ireg_i`[6:0], character code, scan line}, with the code in bits 8..3 and the line in bits 2..0. `rom_addr_vld_o` is 1 from T3 until the pattern is loaded.
- R5: A pattern is loaded at the master edge where T4 is in its third master cycle (CPU clock low). It is shown MSB first, each pixel for 2 master cycles, 8 pixels in all.
- R6: When the invert flag is 1, each pixel of that character is the complement of its pattern bit.
- R7: `video_o` is 0 (background) after reset and once the 8 pixels of the last loaded character have been shown, and no pattern is loaded for a fetch that was not captured.
- R8: The scan-line counter starts at 0, steps by one per `line_adv_i` pulse, wraps from 7 to 0, and is cleared by `frame_start_i`, which wins over `line_adv_i`.
- R9: With CAP_ON_FALL=1 (default) the byte is sampled at the second master edge of T2 (the CPU falling edge). With CAP_ON_FALL=0 it is sampled at the first master edge of T2 (the CPU rising edge), and the bus override starts there.
- R10: `cpu_clk_o` is 1 for the first two master cycles of each T-state and 0 for the last two; after reset a T-state begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstate_i | input | 2 | Current CPU T-state: 0=T1, 1=T2, 2=T3, 3=T4 |
| m1_i | input | 1 | An opcode fetch (with its refresh) is in progress |
| disp_en_i | input | 1 | Current opcode fetch reads the display file |
| data_i | input | 8 | Byte on the memory data bus |
| ireg_i | input | 7 | Upper seven bits of the CPU I register |
| rom_data_i | input | 8 | Pattern byte returned by the character ROM |
| line_adv_i | input | 1 | One-cycle pulse: next scan line |
| frame_start_i | input | 1 | One-cycle pulse: new frame, line counter to 0 |
| cpu_clk_o | output | 1 | Derived CPU clock |
| bus_zero_o | output | 1 | Data bus to the CPU is being forced to zero |
| bus_q_o | output | 8 | Data as presented to the CPU |
| rom_addr_o | output | 16 | Character ROM address |
| rom_addr_vld_o | output | 1 | ROM address belongs to a captured character |
| video_o | output | 1 | Serial pixel output |

## Verification
The assertions assume that `tstate_i` changes only on T-state boundaries set by `cpu_clk_o`. They also assume that `disp_en_i` and `m1_i` stay constant from T1 through T3 of a fetch. The override check and the load check rest on these assumptions. The bench drives every input at the falling master edge and steps in whole T-states of four master cycles from the reset phase. It changes `data_i` inside T2 only in the late-data case, which shows the difference between the two capture edges.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [1:0] {TS_T1 = 2'd0, TS_T2 = 2'd1, TS_T3 = 2'd2, TS_T4 = 2'd3} tstate_e;

  localparam int DATA_W = 8;
  localparam int CODE_W = 6;
  localparam int LINE_W = 3;
  localparam int ADDR_W = 16;

  // pattern ROM address: I-register bits on top, code in the middle, line at the bottom
  function automatic logic [ADDR_W-1:0] pat_addr(
    input logic [ADDR_W-CODE_W-LINE_W-1:0] ihi,
    input logic [CODE_W-1:0]               code,
    input logic [LINE_W-1:0]               line);
    return {ihi, code, line};
  endfunction

  // one pixel of a pattern, index 0 being the first shown (MSB)
  function automatic logic pix_of(input logic [DATA_W-1:0] pat, input logic inv, input int idx);
    return pat[DATA_W-1-idx] ^ inv;
  endfunction
endpackage

// File: rtl/cf_phase_gen.sv
module cf_phase_gen #(
  parameter int PH_PER_T = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic cpu_clk_o,
  output logic rise_evt_o,
  output logic fall_evt_o
);
  localparam int PH_W = (PH_PER_T > 1) ? $clog2(PH_PER_T) : 1;
  localparam int HALF = PH_PER_T / 2;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (ph_q == PH_W'(PH_PER_T - 1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  assign cpu_clk_o  = (ph_q < PH_W'(HALF));
  assign rise_evt_o = (ph_q == '0);
  assign fall_evt_o = (ph_q == PH_W'(HALF));

  AST_CLK_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt_o && PH_PER_T == 4) |=> (!cpu_clk_o ##1 (cpu_clk_o && rise_evt_o))); // R10
endmodule

// File: rtl/cf_fetch_latch.sv
module cf_fetch_latch #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt_i,
  input  logic              load_evt_i,
  input  logic              keep_i,
  input  logic              disp_en_i,
  input  logic              m1_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              inv_o,
  output logic              pend_o,
  output logic              bus_zero_o
);
  logic [CODE_W-1:0] code_q;
  logic              inv_q, pend_q, hold_q;

  // bits between the code field and the invert bit carry no meaning
  logic unused_mid;
  assign unused_mid = ^data_i[DATA_W-2:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      inv_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (cap_evt_i) begin
        code_q <= data_i[CODE_W-1:0];
        inv_q  <= data_i[DATA_W-1];
        pend_q <= 1'b1;
      end else if (load_evt_i) begin
        pend_q <= 1'b0;
      end
      if (cap_evt_i) hold_q <= 1'b1;
      else           hold_q <= hold_q && keep_i && disp_en_i && m1_i;
    end
  end

  assign code_o     = code_q;
  assign inv_o      = inv_q;
  assign pend_o     = pend_q;
  assign bus_zero_o = hold_q;

  AST_ZERO_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_i |=> bus_zero_o); // R2
  AST_ZERO_NEEDS_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_zero_o) |-> $past(disp_en_i && m1_i)); // R3
endmodule

// File: rtl/cf_line_ctr.sv
module cf_line_ctr #(
  parameter int LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv_i,
  input  logic                       clr_i,
  output logic [$clog2(LINES)-1:0]   line_o
);
  localparam int LW = $clog2(LINES);
  logic [LW-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (clr_i) line_q <= '0;
    else if (adv_i) line_q <= (line_q == LW'(LINES - 1)) ? '0 : line_q + 1'b1;
  end

  assign line_o = line_q;

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && line_q == LW'(LINES - 1)) |=> (line_o == '0)); // R8
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (line_o == '0)); // R8
endmodule

// File: rtl/cf_pixel_shifter.sv
module cf_pixel_shifter #(
  parameter int   DATA_W   = 8,
  parameter int   PIX_DIV  = 2,
  parameter logic BG_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] pat_i,
  input  logic              inv_i,
  output logic              video_o
);
  localparam int DIV_W = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  div_q;
  logic              pinv_q;
  logic              pix_step;

  assign pix_step = (div_q == DIV_W'(PIX_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      pinv_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= pat_i;
      cnt_q  <= CNT_W'(DATA_W);
      div_q  <= '0;
      pinv_q <= inv_i;
    end else if (cnt_q != '0) begin
      if (pix_step) begin
        div_q <= '0;
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign video_o = (cnt_q != '0) ? (sh_q[DATA_W-1] ^ pinv_q) : BG_LEVEL;

  AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (video_o == ($past(pat_i[DATA_W-1]) ^ $past(inv_i)))); // R6
  AST_PIXEL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == CNT_W'(DATA_W))); // R5
endmodule

// File: rtl/charfetch_video.sv
module charfetch_video #(
  parameter int   DATA_W      = cf_pkg::DATA_W,
  parameter int   CODE_W      = cf_pkg::CODE_W,
  parameter int   LINE_W      = cf_pkg::LINE_W,
  parameter int   ADDR_W      = cf_pkg::ADDR_W,
  parameter int   PH_PER_T    = 4,
  parameter int   PIX_DIV     = 2,
  parameter bit   CAP_ON_FALL = 1'b1,
  parameter logic BG_LEVEL    = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        tstate_i,
  input  logic                              m1_i,
  input  logic                              disp_en_i,
  input  logic [DATA_W-1:0]                 data_i,
  input  logic [ADDR_W-CODE_W-LINE_W-1:0]   ireg_i,
  input  logic [DATA_W-1:0]                 rom_data_i,
  input  logic                              line_adv_i,
  input  logic                              frame_start_i,
  output logic                              cpu_clk_o,
  output logic                              bus_zero_o,
  output logic [DATA_W-1:0]                 bus_q_o,
  output logic [ADDR_W-1:0]                 rom_addr_o,
  output logic                              rom_addr_vld_o,
  output logic                              video_o
);
  import cf_pkg::*;

  localparam int LINES = 1 << LINE_W;

  // named internal events, shared by the logic and the assertions
  logic              rise_evt, fall_evt, cap_edge, cap_evt, load_evt, keep_zero;
  logic              in_t2, in_t3, in_t4;
  logic [CODE_W-1:0] code;
  logic              inv, pend;
  logic [LINE_W-1:0] line;

  assign in_t2 = (tstate_i == TS_T2);
  assign in_t3 = (tstate_i == TS_T3);
  assign in_t4 = (tstate_i == TS_T4);

  cf_phase_gen #(.PH_PER_T(PH_PER_T)) u_phase (
    .clk(clk), .rst_n(rst_n), .cpu_clk_o(cpu_clk_o),
    .rise_evt_o(rise_evt), .fall_evt_o(fall_evt));

  assign cap_edge  = CAP_ON_FALL ? fall_evt : rise_evt;
  assign cap_evt   = disp_en_i && m1_i && in_t2 && cap_edge;
  assign keep_zero = in_t2 || in_t3;
  assign load_evt  = pend && in_t4 && fall_evt;

  cf_fetch_latch #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cap_evt_i(cap_evt), .load_evt_i(load_evt),
    .keep_i(keep_zero), .disp_en_i(disp_en_i), .m1_i(m1_i), .data_i(data_i),
    .code_o(code), .inv_o(inv), .pend_o(pend), .bus_zero_o(bus_zero_o));

  cf_line_ctr #(.LINES(LINES)) u_line (
    .clk(clk), .rst_n(rst_n), .adv_i(line_adv_i), .clr_i(frame_start_i),
    .line_o(line));

  cf_pixel_shifter #(.DATA_W(DATA_W), .PIX_DIV(PIX_DIV), .BG_LEVEL(BG_LEVEL)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .pat_i(rom_data_i),
    .inv_i(inv), .video_o(video_o));

  assign bus_q_o        = bus_zero_o ? '0 : data_i;
  assign rom_addr_o     = pat_addr(ireg_i, code, line);
  assign rom_addr_vld_o = pend && (in_t3 || in_t4);

  AST_CODE_STABLE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr_vld_o && $past(rom_addr_vld_o)) |-> $stable(rom_addr_o[LINE_W+CODE_W-1:LINE_W])); // R4
  AST_LOAD_CPU_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (!cpu_clk_o && !bus_zero_o)); // R5
endmodule

// File: tb/sim_charfetch_video.sv
`timescale 1ns/1ps
module sim_charfetch_video;
  localparam int CLK_PERIOD = 76;
  localparam int NVEC = 6;
  // {en, data, ireg[6:0], rom, late}
  localparam logic [24:0] VECS [0:NVEC-1] = '{
    {1'b1, 8'h05, 7'h0F, 8'hA5, 1'b0},
    {1'b1, 8'h85, 7'h0F, 8'h3C, 1'b0},
    {1'b0, 8'h41, 7'h22, 8'hFF, 1'b0},
    {1'b1, 8'h7F, 7'h7F, 8'h81, 1'b0},
    {1'b1, 8'hC0, 7'h00, 8'h00, 1'b0},
    {1'b1, 8'h2A, 7'h55, 8'h96, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ts = 2'd0;
  logic m1 = 1'b0, en = 1'b0, ladv = 1'b0, fst = 1'b0;
  logic [7:0] data = 8'h00, rom = 8'h00;
  logic [6:0] ireg = 7'h00;
  logic cclk0, bz0, vld0, vid0, cclk1, bz1, vld1, vid1;
  logic [7:0] bq0, bq1;
  logic [15:0] ad0, ad1;
  int total = 0, bad = 0;
  bit done = 0;
  int exp_line = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  charfetch_video u0 (.clk(clk), .rst_n(rst_n), .tstate_i(ts), .m1_i(m1), .disp_en_i(en),
    .data_i(data), .ireg_i(ireg), .rom_data_i(rom), .line_adv_i(ladv), .frame_start_i(fst),
    .cpu_clk_o(cclk0), .bus_zero_o(bz0), .bus_q_o(bq0), .rom_addr_o(ad0),
    .rom_addr_vld_o(vld0), .video_o(vid0));

  charfetch_video #(.CAP_ON_FALL(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .tstate_i(ts), .m1_i(m1),
    .disp_en_i(en), .data_i(data), .ireg_i(ireg), .rom_data_i(rom), .line_adv_i(ladv),
    .frame_start_i(fst), .cpu_clk_o(cclk1), .bus_zero_o(bz1), .bus_q_o(bq1), .rom_addr_o(ad1),
    .rom_addr_vld_o(vld1), .video_o(vid1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one whole T-state of idle, optionally with a line-control pulse in its first cycle
  task automatic idle_t(input logic adv, input logic clr);
    ts = 2'd0; m1 = 1'b0; ladv = adv; fst = clr;
    step(1);
    ladv = 1'b0; fst = 1'b0;
    step(3);
    if (clr) exp_line = 0;
    else if (adv) exp_line = (exp_line + 1) % 8;
  endtask

  task automatic fetch(input logic f_en, input logic [7:0] f_dat, input logic [6:0] f_ir,
                       input logic [7:0] f_rom, input logic late);
    logic [15:0] exp_a, exp_a1;
    logic [7:0] early;
    early = late ? 8'hEE : f_dat;
    exp_a  = {f_ir, f_dat[5:0], exp_line[2:0]};
    exp_a1 = {f_ir, early[5:0], exp_line[2:0]};
    ts = 2'd0; m1 = 1'b1; en = f_en; data = early; ireg = f_ir; rom = f_rom;
    step(1);
    chk("R10 cpu clock high early in T1", {31'b0, cclk0}, 32'd1);
    step(2);
    chk("R10 cpu clock low late in T1", {31'b0, cclk0}, 32'd0);
    step(1);
    ts = 2'd1;
    step(1);
    chk("R9 falling-edge variant not yet overriding", {24'b0, bq0}, {24'b0, early});
    chk("R9 rising-edge variant overrides at first T2 edge", {31'b0, bz1}, {31'b0, f_en});
    step(1);
    data = f_dat;
    step(1);
    if (f_en) chk("R2 bus forced to zero after capture", {24'b0, bq0}, 32'd0);
    else      chk("R3 bus passes through on normal fetch", {24'b0, bq0}, {24'b0, f_dat});
    step(1);
    ts = 2'd2;
    step(2);
    chk(f_en ? "R2 zero held in T3" : "R3 no override in T3", {31'b0, bz0}, 32'd0 | f_en);
    step(2);
    ts = 2'd3;
    chk("R4 address valid in refresh", {31'b0, vld0}, {31'b0, f_en});
    if (f_en) begin
      chk("R4 R1 pattern address layout", {16'b0, ad0}, {16'b0, exp_a});
      chk("R9 rising variant captured early bus", {16'b0, ad1}, {16'b0, exp_a1});
    end
    step(1);
    chk("R2 override released in T4", {31'b0, bz0}, 32'd0);
    step(2);
    ts = 2'd0; m1 = 1'b0; en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (f_en) chk(f_dat[7] ? "R6 R5 inverted pixel" : "R5 R1 pixel MSB first",
                    {31'b0, vid0}, {31'b0, f_rom[7-k] ^ f_dat[7]});
      else      chk("R7 no load without capture", {31'b0, vid0}, 32'd0);
      step(2);
    end
    chk("R7 background after eight pixels", {31'b0, vid0}, 32'd0);
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R7 video at reset", {31'b0, vid0}, 32'd0);
    chk("R2 no override at reset", {31'b0, bz0}, 32'd0);
    chk("R8 line zero at reset", {29'b0, ad0[2:0]}, 32'd0);
    rst_n = 1'b1;
    chk("R10 reset starts a T-state", {31'b0, cclk0}, 32'd1);

    for (int v = 0; v < NVEC; v++) begin
      fetch(VECS[v][24], VECS[v][23:16], VECS[v][15:9], VECS[v][8:1], VECS[v][0]);
      idle_t(1'b1, 1'b0);
    end

    // line counter corners
    idle_t(1'b0, 1'b1);
    chk("R8 frame start clears line", {29'b0, ad0[2:0]}, 32'd0);
    for (int i = 0; i < 7; i++) idle_t(1'b1, 1'b0);
    chk("R8 line reaches seven", {29'b0, ad0[2:0]}, 32'd7);
    idle_t(1'b1, 1'b0);
    chk("R8 line wraps seven to zero", {29'b0, ad0[2:0]}, 32'd0);
    idle_t(1'b1, 1'b0);
    idle_t(1'b1, 1'b0);
    ladv = 1'b1; fst = 1'b1;
    step(1);
    ladv = 1'b0; fst = 1'b0;
    step(3);
    exp_line = 0;
    chk("R8 frame start wins over advance", {29'b0, ad0[2:0]}, 32'd0);

    // bit 6 has no effect, and a display fetch at a non-zero line
    idle_t(1'b1, 1'b0);
    fetch(1'b1, 8'h4C, 7'h01, 8'hF0, 1'b0);

    // display flag with no opcode fetch: nothing captured
    ts = 2'd1; m1 = 1'b0; en = 1'b1; data = 8'h11;
    step(4);
    chk("R3 no capture without fetch cycle", {24'b0, bq0}, 32'h11);
    ts = 2'd3; en = 1'b0;
    chk("R3 address not valid without capture", {31'b0, vld0}, 32'd0);
    step(4);
    chk("R7 video stays background", {31'b0, vid0}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule